// File: doc/BRIEF.md
# Streaming Fermat-Modulus Number Transform (32 points)

This block computes an exact length-32 number-theoretic transform over the integers modulo 65537 (2^16 + 1) on a continuous sample stream. Input values must already be field residues (0 to 65536), so each word is 17 bits wide. Samples arrive in natural order, one per clock. A frame is 32 consecutive cycles with `in_valid` high, and `in_sof` marks the first of them. Results leave as a stream of the same shape, with their own valid and start-of-frame markers.

The root of unity is 2, so every twiddle factor is a power of two. The block applies each one as a left shift followed by a reduction that uses 2^16 ≡ −1. It contains no general multiplier and no coefficient table. The pipeline has five radix-2 butterfly stages, and each stage keeps its partner samples in a single feedback delay line. The direction is chosen per frame. The inverse uses negated shift exponents (2^32 ≡ 1), then a last stage multiplies by 1/32 ≡ 2^27, which is again a shift. A parameter chooses whether results leave in bit-reversed order or pass through a ping-pong reorder memory and leave in natural order.

Top module: `fermat_xform32`

## Requirements
- R1: In a forward frame, the output for index k is X[k] = Σ_n x[n]·2^(n·k) mod 65537, for k = 0..31.
- R2: In an inverse frame, the output for index n is 2^27·Σ_k X[k]·2^(−n·k) mod 65537. The factor 2^27 is the inverse of 32 modulo 65537.
- R3: With `NATURAL_ORDER` = 0, the word at output position p (0..31 within the frame) carries index rev5(p), where rev5 reverses the five bits of p. With `NATURAL_ORDER` = 1, position p carries index p.
- R4: The residue 65536 is accepted as an input value, and every output word lies in 0..65536.
- R5: `out_sof` rises exactly 37 cycles after the cycle that presents `in_sof` with `in_valid` (bit-reversed order), or 70 cycles after it (natural order).
- R6: Frames may follow each other with no idle cycle between them, and each frame may use a different direction.
- R7: Each output frame is 32 consecutive cycles of `out_valid`, with `out_sof` on the first cycle only. `out_valid` is low outside output frames.
- R8: While `rst_n` is low, and after reset until the first frame emerges, `out_valid` and `out_sof` stay low.
- R9: Cycles with `in_valid` low are ignored, whatever `in_sof`, `in_inverse` and `in_data` carry.
- R10: `in_inverse` is sampled only in the cycle that carries `in_sof` with `in_valid`. Changes to it later in the same frame have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_sof | input | 1 | First sample of a frame (only meaningful with in_valid) |
| in_inverse | input | 1 | Direction for the frame: 0 forward, 1 inverse (sampled with in_sof) |
| in_data | input | 17 | Input residue, 0..65536 |
| out_valid | output | 1 | Output sample present |
| out_sof | output | 1 | First output sample of a frame |
| out_data | output | 17 | Transformed residue, 0..65536 |

## Verification
Unit impulses at positions 0 and 1 give an all-ones frame and a frame of distinct powers of two. The second exposes any error in the output ordering or in a twiddle exponent. A frame filled with 65536 exercises the top residue, which should produce a single nonzero bin of 65505. Random forward and inverse frames, sent back to back with alternating directions, compare every output word with a direct O(N²) modular sum. Frames that toggle `in_inverse` mid-frame, and idle gaps that carry random data and markers, show whether the direction is held for the whole frame and whether invalid cycles are ignored. Both order variants are driven with the same stream and checked on every clock.

// File: rtl/fermat_xform_pkg.sv
`timescale 1ns/1ps
package fermat_xform_pkg;

   localparam int RES_W  = 17;          // residues 0..65536
   localparam int MODV   = 65537;       // 2^16 + 1
   localparam int IDX_W  = 5;           // widest supported index (N = 32)

   typedef logic [RES_W-1:0] resid_t;

   typedef struct packed {
      logic             vld;
      logic             sof;
      logic             inv;
      logic [IDX_W-1:0] idx;
   } tag_t;

   // (a + b) mod 65537
   function automatic resid_t mod_add(resid_t a, resid_t b);
      logic [RES_W:0] s;
      s = {1'b0, a} + {1'b0, b};
      if (s >= (RES_W+1)'(MODV))
         s = s - (RES_W+1)'(MODV);
      return s[RES_W-1:0];
   endfunction

   // (a - b) mod 65537
   function automatic resid_t mod_sub(resid_t a, resid_t b);
      logic [RES_W:0] r;
      if (a >= b)
         r = {1'b0, a} - {1'b0, b};
      else
         r = {1'b0, a} + (RES_W+1)'(MODV) - {1'b0, b};
      return r[RES_W-1:0];
   endfunction

   // v * 2^e mod 65537, e in 0..31, by shift and Fermat reduction.
   // 2^16 = -1, so e >= 16 is a shift by e-16 followed by a negation.
   function automatic resid_t shift_mul(resid_t v, logic [4:0] e);
      logic [32:0]    w;
      logic [16:0]    hi;
      logic [15:0]    lo;
      logic [RES_W:0] r;
      w  = 33'(v) << e[3:0];
      hi = w[32:16];
      lo = w[15:0];
      if ({1'b0, lo} >= hi)
         r = {2'b00, lo} - {1'b0, hi};
      else
         r = {2'b00, lo} + (RES_W+1)'(MODV) - {1'b0, hi};
      if (e[4] && (r != '0))
         r = (RES_W+1)'(MODV) - r;
      return r[RES_W-1:0];
   endfunction

   // reverse the low nb bits of x
   function automatic logic [IDX_W-1:0] bit_rev(logic [IDX_W-1:0] x, int nb);
      logic [IDX_W-1:0] r;
      r = '0;
      for (int i = 0; i < IDX_W; i++)
         if (i < nb)
            r[i] = x[nb-1-i];
      return r;
   endfunction

endpackage

// File: rtl/fermat_sdf_stage.sv
`timescale 1ns/1ps
// One radix-2 butterfly stage with a single feedback delay line.
// Latency: D + 1 cycles, D = N / 2^(STAGE+1).
module fermat_sdf_stage
   import fermat_xform_pkg::*;
#(
   parameter int LOG2N = 5,
   parameter int STAGE = 0
) (
   input  logic   clk,
   input  logic   rst_n,
   input  tag_t   in_tag,
   input  resid_t in_data,
   output tag_t   out_tag,
   output resid_t out_data
);

   localparam int D      = 1 << (LOG2N - 1 - STAGE);
   localparam int PB     = LOG2N - 1 - STAGE;          // half-select bit
   localparam int BSH    = LOG2N - STAGE;              // block index shift
   localparam int STEP   = (1 << (IDX_W - LOG2N)) * D; // exponent per block

   resid_t fifo [D];
   tag_t   tagd [D];

   resid_t           head;
   tag_t             dtag;
   logic             second_half;
   logic [IDX_W-1:0] blk;
   logic [4:0]       e_fwd;
   logic [4:0]       e_sel;
   resid_t           scaled;
   resid_t           sum_v;
   resid_t           diff_v;
   resid_t           push_v;

   assign head        = fifo[D-1];
   assign dtag        = tagd[D-1];
   assign second_half = in_tag.vld & in_tag.idx[PB];
   assign blk         = in_tag.idx >> BSH;
   assign e_fwd       = 5'((STEP * int'(bit_rev(blk, STAGE))) % 32);
   assign e_sel       = in_tag.inv ? (5'd0 - e_fwd) : e_fwd;
   assign scaled      = shift_mul(in_data, e_sel);
   assign sum_v       = mod_add(head, scaled);
   assign diff_v      = mod_sub(head, scaled);
   assign push_v      = second_half ? diff_v : in_data;

   always_ff @(posedge clk) begin
      fifo[0] <= push_v;
      for (int i = 1; i < D; i++)
         fifo[i] <= fifo[i-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < D; i++)
            tagd[i] <= '0;
         out_tag <= '0;
      end else begin
         tagd[0] <= in_tag;
         for (int i = 1; i < D; i++)
            tagd[i] <= tagd[i-1];
         out_tag <= dtag;
      end
   end

   always_ff @(posedge clk) begin
      out_data <= (dtag.vld && dtag.idx[PB]) ? head : sum_v;
   end

endmodule

// File: rtl/fermat_scale.sv
`timescale 1ns/1ps
// Inverse frames are scaled by 1/N = 2^(32 - LOG2N); forward frames pass.
module fermat_scale
   import fermat_xform_pkg::*;
#(
   parameter int LOG2N = 5
) (
   input  logic   clk,
   input  logic   rst_n,
   input  tag_t   in_tag,
   input  resid_t in_data,
   output tag_t   out_tag,
   output resid_t out_data
);

   localparam logic [4:0] INV_N_SH = 5'(32 - LOG2N);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_tag <= '0;
      else        out_tag <= in_tag;
   end

   always_ff @(posedge clk) begin
      out_data <= in_tag.inv ? shift_mul(in_data, INV_N_SH) : in_data;
   end

endmodule

// File: rtl/fermat_reorder.sv
`timescale 1ns/1ps
// Ping-pong buffer turning bit-reversed frames into natural order.
// Latency: N + 1 cycles.
module fermat_reorder
   import fermat_xform_pkg::*;
#(
   parameter int LOG2N = 5
) (
   input  logic   clk,
   input  logic   rst_n,
   input  tag_t   in_tag,
   input  resid_t in_data,
   output tag_t   out_tag,
   output resid_t out_data
);

   localparam int N      = 1 << LOG2N;
   localparam int ADDR_W = LOG2N + 1;

   typedef struct packed {
      tag_t tag;
      logic bank;
   } slot_t;

   resid_t mem [2*N];
   slot_t  dly [N];
   logic   wbank_q;
   logic   wbank;
   slot_t  rd;

   logic [ADDR_W-1:0] waddr;
   logic [ADDR_W-1:0] raddr;

   assign wbank = (in_tag.vld && in_tag.sof) ? ~wbank_q : wbank_q;
   assign waddr = {wbank, bit_rev(in_tag.idx, LOG2N)[LOG2N-1:0]};
   assign rd    = dly[N-1];
   assign raddr = {rd.bank, rd.tag.idx[LOG2N-1:0]};

   always_ff @(posedge clk) begin
      if (in_tag.vld)
         mem[waddr] <= in_data;
      out_data <= mem[raddr];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbank_q <= 1'b1;
         for (int i = 0; i < N; i++)
            dly[i] <= '0;
         out_tag <= '0;
      end else begin
         if (in_tag.vld)
            wbank_q <= wbank;
         dly[0] <= '{tag: in_tag, bank: wbank};
         for (int i = 1; i < N; i++)
            dly[i] <= dly[i-1];
         out_tag <= rd.tag;
      end
   end

endmodule

// File: rtl/fermat_xform32.sv
`timescale 1ns/1ps
module fermat_xform32
   import fermat_xform_pkg::*;
#(
   parameter int LOG2N         = 5,
   parameter bit NATURAL_ORDER = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic               in_sof,
   input  logic               in_inverse,
   input  logic [RES_W-1:0]   in_data,
   output logic               out_valid,
   output logic               out_sof,
   output logic [RES_W-1:0]   out_data
);

   localparam int N = 1 << LOG2N;

   if (LOG2N < 1 || LOG2N > IDX_W) begin : g_bad_len
      $error("LOG2N must lie in 1..5 for root 2 modulo 65537");
   end

   // frame index and direction tracking
   logic [IDX_W-1:0] cnt_q;
   logic             mode_q;
   logic [IDX_W-1:0] cur_idx;
   logic             cur_inv;
   tag_t             tag0;

   assign cur_idx = in_sof ? '0 : cnt_q;
   assign cur_inv = in_sof ? in_inverse : mode_q;
   assign tag0    = '{vld: in_valid, sof: in_valid & in_sof, inv: cur_inv, idx: cur_idx};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         mode_q <= 1'b0;
      end else if (in_valid) begin
         cnt_q  <= (cur_idx + IDX_W'(1)) & IDX_W'(N - 1);
         mode_q <= cur_inv;
      end
   end

   // butterfly stages
   tag_t   st_tag  [LOG2N+1];
   resid_t st_data [LOG2N+1];

   assign st_tag[0]  = tag0;
   assign st_data[0] = in_data;

   for (genvar s = 0; s < LOG2N; s++) begin : g_stage
      fermat_sdf_stage #(
         .LOG2N (LOG2N),
         .STAGE (s)
      ) u_stage (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_tag   (st_tag[s]),
         .in_data  (st_data[s]),
         .out_tag  (st_tag[s+1]),
         .out_data (st_data[s+1])
      );
   end

   tag_t   sc_tag;
   resid_t sc_data;

   fermat_scale #(.LOG2N(LOG2N)) u_scale (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_tag   (st_tag[LOG2N]),
      .in_data  (st_data[LOG2N]),
      .out_tag  (sc_tag),
      .out_data (sc_data)
   );

   tag_t   fin_tag;
   resid_t fin_data;

   if (NATURAL_ORDER) begin : g_natural
      fermat_reorder #(.LOG2N(LOG2N)) u_reorder (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_tag   (sc_tag),
         .in_data  (sc_data),
         .out_tag  (fin_tag),
         .out_data (fin_data)
      );
   end else begin : g_bitrev
      assign fin_tag  = sc_tag;
      assign fin_data = sc_data;
   end

   assign out_valid = fin_tag.vld;
   assign out_sof   = fin_tag.sof;
   assign out_data  = fin_data;

   logic unused_tag_bits;
   assign unused_tag_bits = ^{fin_tag.inv, fin_tag.idx};

endmodule

// File: rtl/fermat_xform_chk.sv
`timescale 1ns/1ps
module fermat_xform_chk #(
   parameter int LOG2N         = 5,
   parameter bit NATURAL_ORDER = 1'b0
) (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic        in_sof,
   input logic        out_valid,
   input logic        out_sof,
   input logic [16:0] out_data
);

   localparam int N   = 1 << LOG2N;
   localparam int LAT = (N - 1) + LOG2N + 1 + (NATURAL_ORDER ? N + 1 : 0);

   logic [LAT-1:0] sof_pipe;
   logic [4:0]     ocnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sof_pipe <= '0;
         ocnt     <= '0;
      end else begin
         sof_pipe <= {sof_pipe[LAT-2:0], in_valid & in_sof};
         if (out_valid)
            ocnt <= (out_sof ? 5'd1 : ocnt + 5'd1) & 5'(N - 1);
      end
   end

   assert_sof_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof == sof_pipe[LAT-1]);

   assert_residue_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data <= 17'd65536));

   assert_sof_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> out_valid);

   assert_frame_complete_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> (ocnt == 5'd0));

   assert_frame_contiguous_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ocnt != 5'd0) |-> (out_valid && !out_sof));

   assert_no_orphan_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_sof) |-> (ocnt != 5'd0));

endmodule

bind fermat_xform32 fermat_xform_chk #(
   .LOG2N         (LOG2N),
   .NATURAL_ORDER (NATURAL_ORDER)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_sof    (in_sof),
   .out_valid (out_valid),
   .out_sof   (out_sof),
   .out_data  (out_data)
);

// File: tb/tb_fermat_xform32.sv
`timescale 1ns/1ps
module tb_fermat_xform32;

   localparam int N       = 32;
   localparam int P       = 65537;
   localparam int LAT_BR  = 37;
   localparam int LAT_NAT = 70;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid, in_sof, in_inverse;
   logic [16:0] in_data;
   logic        br_valid, br_sof, nat_valid, nat_sof;
   logic [16:0] br_data, nat_data;

   always #4 clk = ~clk;   // 125 MHz

   fermat_xform32 dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_inverse(in_inverse), .in_data(in_data),
      .out_valid(br_valid), .out_sof(br_sof), .out_data(br_data));

   fermat_xform32 #(.NATURAL_ORDER(1'b1)) dut_nat (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_inverse(in_inverse), .in_data(in_data),
      .out_valid(nat_valid), .out_sof(nat_sof), .out_data(nat_data));

   typedef struct {
      int    cyc;
      int    val;
      bit    sof;
      string req;
   } exp_t;

   exp_t expq [2][$];
   int   errors = 0;
   int   checks = 0;
   int   cyc    = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic longint pow2m(int e);
      longint r = 1;
      for (int i = 0; i < (e % 32); i++) r = (r * 2) % P;
      return r;
   endfunction

   function automatic int rev5(int p);
      int r = 0;
      for (int i = 0; i < 5; i++) if (p[i]) r[4-i] = 1'b1;
      return r;
   endfunction

   task automatic fail(string req, string what, int act, int expv);
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, expv, cyc);
   endtask

   task automatic chk(int w, logic v, logic s, logic [16:0] d);
      exp_t e;
      checks++;
      if (v && d > 17'd65536) fail("R4", "residue out of range", int'(d), 65536);
      if (expq[w].size() > 0 && expq[w][0].cyc == cyc) begin
         e = expq[w].pop_front();
         if (!v)                 fail("R7", "missing out_valid", 0, 1);
         else if (s != e.sof)    fail("R5", "out_sof timing", int'(s), int'(e.sof));
         else if (int'(d) != e.val) fail(e.req, "output word", int'(d), e.val);
      end else if (v) begin
         fail("R7", "unexpected out_valid", 1, 0);
      end
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         checks++;
         if (br_valid || nat_valid || br_sof || nat_sof)
            fail("R8", "output active in reset", 1, 0);
      end else begin
         chk(0, br_valid, br_sof, br_data);
         chk(1, nat_valid, nat_sof, nat_data);
      end
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   always @(posedge clk) begin
      if (cyc > 5000) begin
         errors++;
         $display("FAIL R7 watchdog expired: actual=%0d expected=<5000", cyc);
         summary();
         $finish;
      end
   end

   // Sends one frame, records the expected output of both order variants.
   task automatic send_frame(int x[N], bit inv, string req, int gap, bit flip_mid);
      int     xo[N];
      longint acc;
      int     base;
      for (int k = 0; k < N; k++) begin
         acc = 0;
         for (int n = 0; n < N; n++) begin
            int e = (n * k) % 32;
            if (inv) e = (32 - e) % 32;
            acc = (acc + longint'(x[n]) * pow2m(e)) % P;
         end
         if (inv) acc = (acc * pow2m(27)) % P;
         xo[k] = int'(acc);
      end
      for (int n = 0; n < N; n++) begin
         @(negedge clk);
         if (n == 0) begin
            base = cyc;
            for (int p = 0; p < N; p++) begin
               expq[0].push_back('{cyc: base + LAT_BR + p,  val: xo[rev5(p)], sof: (p == 0), req: req});
               expq[1].push_back('{cyc: base + LAT_NAT + p, val: xo[p],       sof: (p == 0), req: req});
            end
         end
         in_valid   = 1'b1;
         in_sof     = (n == 0);
         in_inverse = (n == 0) ? inv : (flip_mid ? ~inv : inv);
         in_data    = 17'(x[n]);
      end
      for (int g = 0; g < gap; g++) begin
         @(negedge clk);
         in_valid   = 1'b0;
         in_sof     = 1'($urandom);
         in_inverse = 1'($urandom);
         in_data    = 17'($urandom % P);
      end
   endtask

   initial begin
      int x[N];
      rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_inverse = 1'b0; in_data = '0;
      repeat (6) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1: impulse at 0 -> all ones
      foreach (x[i]) x[i] = (i == 0) ? 1 : 0;
      send_frame(x, 1'b0, "R1", 3, 1'b0);
      // R3: impulse at 1 -> distinct powers of two expose ordering
      foreach (x[i]) x[i] = (i == 1) ? 1 : 0;
      send_frame(x, 1'b0, "R3", 0, 1'b0);
      // R4: top residue everywhere
      foreach (x[i]) x[i] = 65536;
      send_frame(x, 1'b0, "R4", 2, 1'b0);
      // R1: random forward
      foreach (x[i]) x[i] = int'($urandom % P);
      send_frame(x, 1'b0, "R1", 0, 1'b0);
      // R2: random inverse, back to back after a forward frame
      foreach (x[i]) x[i] = int'($urandom % P);
      send_frame(x, 1'b1, "R2", 0, 1'b0);
      // R10: direction toggled mid-frame must be ignored; gap carries garbage
      foreach (x[i]) x[i] = int'($urandom % P);
      send_frame(x, 1'b1, "R10", 7, 1'b1);
      // R9: frame after a garbage-filled idle gap
      foreach (x[i]) x[i] = int'($urandom % P);
      send_frame(x, 1'b0, "R9", 5, 1'b1);
      // R6: back-to-back frames with alternating direction
      for (int f = 0; f < 6; f++) begin
         foreach (x[i]) x[i] = int'($urandom % P);
         send_frame(x, f[0], "R6", 0, 1'b0);
      end
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0;

      repeat (LAT_NAT + N + 10) @(negedge clk);
      for (int w = 0; w < 2; w++) begin
         checks++;
         if (expq[w].size() != 0) fail("R7", "outputs never produced", 0, expq[w].size());
      end
      summary();
      $finish;
   end

endmodule